// File: doc/BRIEF.md
# Reference Clock Low-Frequency Power-Down Guard

This block watches an incoming reference clock from a free-running local clock and decides whether that reference is fast enough to run from. The reference is first divided down in its own domain by a small free-running binary counter. The top bit of that counter is carried into the local domain through a synchroniser, and its rising edges are counted over a fixed window of local cycles. A window that gathers fewer edges than a threshold counts as low frequency. The threshold is set so that the boundary falls near 20 MHz. A reference that has stopped gathers no edges, so it falls under the same rule.

The detector's verdict is combined with an active-low external power-down pin into a single power-down output. Driving the pin low and having a slow input have exactly the same effect downstream: receivers off, PLL off, outputs in high impedance. The detector keeps measuring while the pin is low. When the combined power-down is released, the block raises a one-cycle relock request so that the PLL re-acquires phase lock.

Entry into low-power mode takes one bad window. Leaving it takes two good windows in a row. Reset starts the block in power-down. The divided reference must have a half period longer than two local cycles for the count to be valid, and the parameters are chosen with that constraint in mind.

Top module: `refclk_lowfreq_guard`

## Requirements
- R1: While reset is asserted and until the detector releases, `pwr_down` is 1 and `relock_req` is 0.
- R2: Measurement windows are `WIN_CYCLES` local cycles long and end on every `WIN_CYCLES`-th local rising edge after reset is released. The detector state changes only at a window end. A window counts as above threshold when it has seen at least `MIN_EDGES` rising edges of the reference divided by 2^`PRESC_BITS`.
- R3: A single window below threshold puts the detector in low-frequency state at that window's end, and `pwr_down` goes to 1 in the following cycle.
- R4: Low-frequency state is left only after two consecutive above-threshold windows. One good window, whether alone or followed by a bad one, leaves `pwr_down` at 1. The release takes effect at the end of the second good window.
- R5: A stopped reference clock yields below-threshold windows and therefore power-down. Power-down is lifted again by two good windows once the clock resumes.
- R6: `pwr_down` is the OR of NOT `pd_n` and the detector's low-frequency flag. A low `pd_n` forces `pwr_down` to 1 without waiting for a clock edge, and a high `pd_n` cannot lift a power-down caused by a slow input.
- R7: The detector keeps measuring while `pd_n` is low. If the reference stayed fast, raising `pd_n` clears `pwr_down` at once, with no window wait.
- R8: `relock_req` is 1 for exactly one local cycle. It is registered and goes high in the cycle after `pwr_down` falls from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_loc | input | 1 | Free-running local clock (measurement timebase) |
| rst | input | 1 | Asynchronous active-high reset |
| clk_mon | input | 1 | Reference clock whose frequency is monitored |
| pd_n | input | 1 | External power-down pin, active low |
| pwr_down | output | 1 | Combined power-down (pin or low frequency) |
| relock_req | output | 1 | One-cycle pulse asking the PLL to re-acquire lock |

## Verification
The bench changes the reference rate exactly at window boundaries, which it derives by counting local cycles from reset. It then checks the power-down output one cycle before and one cycle after each boundary. A design that released after a single good window, or that checked the threshold off by one window, fails at those cycles. The sequence includes a lone good window between two slow ones, a fully stopped input, and a pin pulse during both fast and slow input. A detector that froze while the pin was low, or a pin that could override a slow input, therefore shows up as a wrong level. The exact width and timing of the relock pulse after each release are also checked, which catches a level that stays high or a pulse that lands in the wrong cycle.

// File: rtl/lfpd_pkg.sv
package lfpd_pkg;
    typedef enum logic [1:0] {
        ST_DOWN = 2'd0,
        ST_PEND = 2'd1,
        ST_RUN  = 2'd2
    } det_state_e;
endpackage

// File: rtl/lfpd_prescaler.sv
module lfpd_prescaler #(
    parameter int PRESC_BITS  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_mon,
    input  logic clk_loc,
    input  logic rst,
    output logic edge_pulse
);
    localparam int MSB = PRESC_BITS - 1;

    logic [PRESC_BITS-1:0] div_d, div_q;

    always_comb div_d = div_q + 1'b1;

    always_ff @(posedge clk_mon or posedge rst) begin
        if (rst) div_q <= '0;
        else     div_q <= div_d;
    end

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], div_q[MSB]};
        s_d.last = s_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk_loc or posedge rst) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign edge_pulse = s_q.sync[SYNC_STAGES-1] & ~s_q.last;
endmodule

// File: rtl/lfpd_window.sv
module lfpd_window #(
    parameter int WIN_CYCLES = 256,
    parameter int MIN_EDGES  = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_pulse,
    output logic win_done,
    output logic win_above
);
    localparam int WW = $clog2(WIN_CYCLES);
    localparam int EW = $clog2(MIN_EDGES + 1);
    localparam logic [WW-1:0] POS_LAST = WW'(WIN_CYCLES - 1);
    localparam logic [EW-1:0] EDGE_SAT = EW'(MIN_EDGES);

    typedef struct packed {
        logic [WW-1:0] pos;
        logic [EW-1:0] edges;
    } win_t;

    win_t w_d, w_q;
    logic [EW-1:0] edges_inc;

    always_comb begin
        edges_inc = (w_q.edges == EDGE_SAT) ? w_q.edges
                                            : w_q.edges + EW'(edge_pulse);
        win_done  = (w_q.pos == POS_LAST);
        win_above = (edges_inc == EDGE_SAT);
        w_d       = w_q;
        if (win_done) begin
            w_d.pos   = '0;
            w_d.edges = '0;
        end else begin
            w_d.pos   = w_q.pos + 1'b1;
            w_d.edges = edges_inc;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) w_q <= '0;
        else     w_q <= w_d;
    end

    // R2
    edge_cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        w_q.edges <= EDGE_SAT);
    // R2
    window_restart_chk: assert property (@(posedge clk) disable iff (rst)
        win_done |=> (w_q.pos == '0 && w_q.edges == '0));
    // R2
    window_gap_chk: assert property (@(posedge clk) disable iff (rst)
        win_done |=> !win_done);
endmodule

// File: rtl/lfpd_hyst.sv
module lfpd_hyst
    import lfpd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic win_done,
    input  logic win_above,
    output logic low_freq
);
    det_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (win_done) begin
            if (!win_above) begin
                st_d = ST_DOWN;
            end else begin
                case (st_q)
                    ST_DOWN: st_d = ST_PEND;
                    ST_PEND: st_d = ST_RUN;
                    default: st_d = ST_RUN;
                endcase
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= ST_DOWN;
        else     st_q <= st_d;
    end

    assign low_freq = (st_q != ST_RUN);

    // R2
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !win_done |=> $stable(st_q));
    // R3
    slow_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (win_done && !win_above) |=> st_q == ST_DOWN);
    // R4
    run_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && $past(st_q) != ST_RUN) |-> $past(st_q) == ST_PEND);
endmodule

// File: rtl/refclk_lowfreq_guard.sv
module refclk_lowfreq_guard #(
    parameter int PRESC_BITS  = 3,
    parameter int SYNC_STAGES = 2,
    parameter int WIN_CYCLES  = 256,
    parameter int MIN_EDGES   = 13
) (
    input  logic clk_loc,
    input  logic rst,
    input  logic clk_mon,
    input  logic pd_n,
    output logic pwr_down,
    output logic relock_req
);
    logic edge_pulse, win_done, win_above, low_freq;

    lfpd_prescaler #(.PRESC_BITS(PRESC_BITS), .SYNC_STAGES(SYNC_STAGES)) u_presc (
        .clk_mon    (clk_mon),
        .clk_loc    (clk_loc),
        .rst        (rst),
        .edge_pulse (edge_pulse)
    );

    lfpd_window #(.WIN_CYCLES(WIN_CYCLES), .MIN_EDGES(MIN_EDGES)) u_win (
        .clk        (clk_loc),
        .rst        (rst),
        .edge_pulse (edge_pulse),
        .win_done   (win_done),
        .win_above  (win_above)
    );

    lfpd_hyst u_hyst (
        .clk       (clk_loc),
        .rst       (rst),
        .win_done  (win_done),
        .win_above (win_above),
        .low_freq  (low_freq)
    );

    typedef struct packed {
        logic prev_pd;
        logic relock;
    } top_t;

    top_t t_d, t_q;

    always_comb begin
        pwr_down   = ~pd_n | low_freq;
        t_d        = t_q;
        t_d.prev_pd = pwr_down;
        t_d.relock  = t_q.prev_pd & ~pwr_down;
    end

    always_ff @(posedge clk_loc or posedge rst) begin
        if (rst) t_q <= '{prev_pd: 1'b1, relock: 1'b0};
        else     t_q <= t_d;
    end

    assign relock_req = t_q.relock;

    // R8
    relock_pulse_chk: assert property (@(posedge clk_loc) disable iff (rst)
        relock_req |=> !relock_req);
    // R8
    relock_cause_chk: assert property (@(posedge clk_loc) disable iff (rst)
        relock_req |-> ($past(pwr_down, 2) && !$past(pwr_down)));
    // R1
    reset_down_chk: assert property (@(posedge clk_loc)
        rst |-> (pwr_down && !relock_req));
endmodule

// File: tb/refclk_lowfreq_guard_test.sv
`timescale 1ns/1ps
module refclk_lowfreq_guard_test;
    logic clk = 0, rst = 1, mclk = 0, pd_n = 1;
    logic pwr_down, relock_req;
    int   half_ns = 12;
    int   cyc = 0;
    int   checks = 0, errors = 0;
    bit   done = 0;

    typedef struct {
        int    at;
        bit    pd;
        bit    rl;
        string req;
    } exp_t;
    exp_t sb[$];

    refclk_lowfreq_guard uut (
        .clk_loc(clk), .rst(rst), .clk_mon(mclk), .pd_n(pd_n),
        .pwr_down(pwr_down), .relock_req(relock_req)
    );

    always #10 clk = ~clk;

    initial forever begin
        if (half_ns == 0) #4;
        else #(half_ns) mclk = ~mclk;
    end

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic push_exp(input int at, input bit pd, input bit rl, input string req);
        exp_t e;
        e.at = at; e.pd = pd; e.rl = rl; e.req = req;
        sb.push_back(e);
    endtask

    task automatic check(input string req, input bit got_pd, input bit got_rl,
                         input bit exp_pd, input bit exp_rl);
        checks++;
        if (got_pd !== exp_pd || got_rl !== exp_rl) begin
            errors++;
            $display("FAIL %s cyc %0d: pwr_down=%b relock_req=%b expected %b %b",
                     req, cyc, got_pd, got_rl, exp_pd, exp_rl);
        end
    endtask

    task automatic wait_cycle(input int k);
        do begin
            @(posedge clk);
            #1;
        end while (cyc != k);
        #1;
    endtask

    // monitor: pops expected items when their cycle is reached
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at == cyc && !rst) begin
            check(sb[0].req, pwr_down, relock_req, sb[0].pd, sb[0].rl);
            void'(sb.pop_front());
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired at cyc %0d", cyc);
        finish_run();
    end

    initial begin
        // driver: expected scoreboard items in cycle order
        push_exp(255,  1, 0, "R1 down before first windows");
        push_exp(256,  1, 0, "R4 one good window not enough");
        push_exp(511,  1, 0, "R4 still down before 2nd window end");
        push_exp(512,  0, 0, "R4 release after two good windows");
        push_exp(513,  0, 1, "R8 relock pulse");
        push_exp(514,  0, 0, "R8 pulse one cycle");
        push_exp(1279, 0, 0, "R3 up until slow window ends");
        push_exp(1280, 1, 0, "R3 slow window forces down");
        push_exp(1536, 1, 0, "R4 lone good window");
        push_exp(1792, 1, 0, "R4 good then bad stays down");
        push_exp(2048, 1, 0, "R4 first good after bad");
        push_exp(2304, 0, 0, "R4 second good releases");
        push_exp(2305, 0, 1, "R8 relock after release");
        push_exp(2306, 0, 0, "R8 pulse ends");
        push_exp(2560, 1, 0, "R5 stopped clock down");
        push_exp(2816, 1, 0, "R5 still stopped");
        push_exp(3072, 1, 0, "R5 first window after resume");
        push_exp(3328, 0, 0, "R5 recovered");
        push_exp(3329, 0, 1, "R8 relock after resume");
        push_exp(3400, 1, 0, "R6 pin forces down at once");
        push_exp(3401, 1, 0, "R6 pin held");
        push_exp(3584, 1, 0, "R7 detector runs under pin");
        push_exp(3700, 0, 0, "R7 pin release immediate");
        push_exp(3701, 0, 1, "R8 relock after pin release");
        push_exp(3702, 0, 0, "R8 pulse ends");
        push_exp(4096, 1, 0, "R3 slow again");
        push_exp(4200, 1, 0, "R6 pin low while slow");
        push_exp(4250, 1, 0, "R6 pin high cannot lift slow");
        push_exp(4251, 1, 0, "R6 no relock while slow");

        repeat (5) @(posedge clk);
        #5;
        check("R1 reset state", pwr_down, relock_req, 1'b1, 1'b0);
        @(posedge clk);
        #2 rst = 0;

        wait_cycle(1024); half_ns = 50;
        wait_cycle(1280); half_ns = 12;
        wait_cycle(1536); half_ns = 50;
        wait_cycle(1792); half_ns = 12;
        wait_cycle(2304); half_ns = 0;
        wait_cycle(2816); half_ns = 12;
        wait_cycle(3400); pd_n = 0;
        wait_cycle(3700); pd_n = 1;
        wait_cycle(3840); half_ns = 50;
        wait_cycle(4200); pd_n = 0;
        wait_cycle(4250); pd_n = 1;
        wait_cycle(4300);

        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R2 scoreboard left %0d items, expected 0", sb.size());
        end
        finish_run();
    end
endmodule